// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the target side of a two-wire serial bus in front of a 2048-by-8 storage array. A fast system clock samples the bus clock and data lines through a synchronizer. The block detects start and stop conditions and moves 8-bit words most significant bit first. It takes part in the ninth-clock acknowledge by pulling the data line low through an open-drain enable.

A controller addresses the block with a device word. The upper four bits of that word are the code 1010, the next three bits are memory address bits 10 to 8, and the last bit selects read (1) or write (0). A write carries one low address byte followed by data bytes. The data bytes collect in a 16-byte page buffer, and a stop hands them to a timed write cycle. A read returns data at an internal address counter. That counter is set by a write, so a read that follows an address-only write becomes a random read. A read keeps streaming while the controller acknowledges.

A write-protect input blocks every array update but leaves reads untouched. While the timed write cycle runs, the block answers no device word, so a controller can poll for completion.

Top module: `eep_i2c_target`

## Requirements
- R1: START is the data line falling while the clock line is high. STOP is the data line rising while the clock line is high. Either one, seen in any state, ends the transfer in progress and releases the data line. Partly received write data is dropped and never written.
- R2: A device word whose upper four bits are not 1010 gets no acknowledge. The block then ignores the bus until the next START or STOP.
- R3: Input bits are taken on the rising clock edge. sda_oe changes only while the clock line is low. Read data leaves most significant bit first, and an acknowledge is a low level during the ninth clock.
- R4: In a write, the address byte and device-word bits 3..1 together load the 11-bit address counter. Each data byte is acknowledged and stored at the counter. The counter's low 4 bits then advance, and its upper 7 bits never change.
- R5: Page writes wrap within the 16-byte page. Bytes past the page end overwrite the page start. After 16 bytes written from offset 0, the counter points back at the page start.
- R6: With wp high, the device word and the address byte are acknowledged, every data byte is not acknowledged, no array location changes, and no write cycle starts.
- R7: A read device word returns data at the address counter, which holds the last accessed address plus one. The device word's address bits are ignored on a read.
- R8: An address-only write, then a repeated START and a read device word, returns data at the address just loaded.
- R9: In a read, a controller acknowledge (0) moves to the next address and sends its byte. The address wraps from 0x7FF to 0x000.
- R10: After a controller no-acknowledge (1), the block releases the data line and sends nothing until START or STOP. The counter then points one past the last byte sent.
- R11: A STOP that ends a write holding at least one data byte starts a write cycle of WC_CYCLES clocks. During that cycle a device word gets no acknowledge. Afterwards the block acknowledges again and the data is readable.
- R12: Reset clears the address counter to 0 and leaves sda_oe low. Array contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| wp | input | 1 | Write protect, high blocks all writes |
| sda_oe | output | 1 | When high, pulls the data line low |

## Verification
The bench writes a page starting near its end and reads both the wrapped bytes and the counter position. A design that carried into bit 4 would spill into the next page, or would return the wrong byte on a current-address read. A sequential read across 0x7FF must come back to 0x000, where a clamped or page-limited counter would repeat data. Write protect is checked in two places: on the acknowledge of the data bytes, and on later reads, which expose any design that buffered the data anyway. The bench also polls during the write cycle, sends a wrong device code, issues a START in the middle of a data byte, and keeps clocking after a no-acknowledge. A design that ignored the busy window, answered a foreign code, stored a partial byte or kept driving after the no-acknowledge would fail these checks.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_HOLD
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_q[0] <= 1'b1;
            sda_q[0] <= 1'b1;
          end else begin
            scl_q[0] <= scl_in;
            sda_q[0] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_q[g] <= 1'b1;
            sda_q[g] <= 1'b1;
          end else begin
            scl_q[g] <= scl_q[g-1];
            sda_q[g] <= sda_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eep_wbuf.sv
module eep_wbuf #(
  parameter int AW        = 11,
  parameter int PW        = 4,
  parameter int WC_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             put,
  input  logic [PW-1:0]    put_idx,
  input  logic [7:0]       put_data,
  input  logic             commit_req,
  input  logic [AW-PW-1:0] commit_base,
  output logic             busy,
  output logic [(1<<PW)-1:0] buf_valid,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [7:0]       ram_wdata
);
  localparam int PAGE = 1 << PW;
  localparam int CW   = $clog2(WC_CYCLES + 1);

  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  valid_n;
  logic [CW-1:0]    wc_cnt;
  logic [CW-1:0]    wc_cnt_n;
  logic             busy_n;
  logic [AW-PW-1:0] base_q;
  logic [AW-PW-1:0] base_n;
  logic             launch;
  logic             finish;

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (put && !busy && put_idx == PW'(g)) pbuf[g] <= put_data;
      end
    end
  endgenerate

  assign launch = commit_req && !busy && (|buf_valid);
  assign finish = busy && (wc_cnt == CW'(WC_CYCLES - 1));

  always_comb begin
    valid_n  = buf_valid;
    busy_n   = busy;
    wc_cnt_n = wc_cnt;
    base_n   = base_q;
    if (launch) begin
      busy_n   = 1'b1;
      wc_cnt_n = '0;
      base_n   = commit_base;
    end else if (finish) begin
      busy_n  = 1'b0;
      valid_n = '0;
    end else if (busy) begin
      wc_cnt_n = wc_cnt + 1'b1;
    end else if (clear) begin
      valid_n = '0;
    end else if (put) begin
      valid_n[put_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= '0;
      busy      <= 1'b0;
      wc_cnt    <= '0;
      base_q    <= '0;
    end else begin
      buf_valid <= valid_n;
      busy      <= busy_n;
      wc_cnt    <= wc_cnt_n;
      base_q    <= base_n;
    end
  end

  assign ram_we    = busy && (wc_cnt < CW'(PAGE)) && buf_valid[wc_cnt[PW-1:0]];
  assign ram_waddr = {base_q, wc_cnt[PW-1:0]};
  assign ram_wdata = pbuf[wc_cnt[PW-1:0]];
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
  import eep_pkg::*;
#(
  parameter int AW          = 11,
  parameter int PW          = 4,
  parameter int WC_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp,
  output logic sda_oe
);
  localparam int HIW = AW - 8;

  logic       rst_q1;
  logic       rst_sn;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_evt;
  logic       stop_evt;

  eep_state_e state;
  eep_state_e state_n;
  eep_state_e nxt;
  eep_state_e nxt_n;
  logic [3:0]     cnt;
  logic [3:0]     cnt_n;
  logic [7:0]     sh;
  logic [7:0]     sh_n;
  logic           oe_n;
  logic           ack;
  logic           ack_n;
  logic [AW-1:0]  addr;
  logic [AW-1:0]  addr_n;
  logic [HIW-1:0] hi;
  logic [HIW-1:0] hi_n;
  logic [7:0]     byte_in;

  logic           put;
  logic           clr;
  logic           commit;
  logic           busy;
  logic [(1<<PW)-1:0] buf_valid;
  logic           ram_we;
  logic [AW-1:0]  ram_waddr;
  logic [7:0]     ram_wdata;
  logic [7:0]     rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_sn <= rst_q1;
    end
  end

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  eep_wbuf #(.AW(AW), .PW(PW), .WC_CYCLES(WC_CYCLES)) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_sn),
    .clear       (clr),
    .put         (put),
    .put_idx     (addr[PW-1:0]),
    .put_data    (byte_in),
    .commit_req  (commit),
    .commit_base (addr[AW-1:PW]),
    .busy        (busy),
    .buf_valid   (buf_valid),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .ram_wdata   (ram_wdata)
  );

  eep_ram #(.AW(AW), .DW(8)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (addr),
    .rdata (rdata)
  );

  assign byte_in = {sh[6:0], sda_s};

  always_comb begin
    state_n = state;
    nxt_n   = nxt;
    cnt_n   = cnt;
    sh_n    = sh;
    oe_n    = sda_oe;
    ack_n   = ack;
    addr_n  = addr;
    hi_n    = hi;
    put     = 1'b0;
    clr     = 1'b0;
    commit  = 1'b0;
    if (start_evt) begin
      state_n = ST_DEV;
      cnt_n   = '0;
      oe_n    = 1'b0;
      clr     = 1'b1;
    end else if (stop_evt) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      oe_n    = 1'b0;
      commit  = 1'b1;
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
            if (cnt < 4'd8) sh_n = byte_in;
            if (cnt == 4'd7) begin
              if (state == ST_DEV) begin
                if (byte_in[7:4] == DEV_CODE && !busy) begin
                  ack_n = 1'b1;
                  hi_n  = byte_in[HIW:1];
                  nxt_n = byte_in[0] ? ST_RD : ST_ADDR;
                end else begin
                  ack_n = 1'b0;
                  nxt_n = ST_HOLD;
                end
              end else if (state == ST_ADDR) begin
                ack_n  = 1'b1;
                addr_n = {hi, byte_in};
                clr    = 1'b1;
                nxt_n  = ST_WR;
              end else begin
                nxt_n = ST_WR;
                ack_n = !wp;
                if (!wp) begin
                  put    = 1'b1;
                  addr_n = {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
                end
              end
            end
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_n = ack;
            end else if (cnt == 4'd9) begin
              cnt_n   = '0;
              state_n = nxt;
              if (nxt == ST_RD) begin
                oe_n = ~rdata[7];
                sh_n = {rdata[6:0], 1'b0};
              end else begin
                oe_n = 1'b0;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
            if (cnt == 4'd8) begin
              addr_n = addr + 1'b1;
              nxt_n  = sda_s ? ST_HOLD : ST_RD;
            end
          end else if (scl_fall) begin
            if (cnt < 4'd8) begin
              oe_n = ~sh[7];
              sh_n = {sh[6:0], 1'b0};
            end else if (cnt == 4'd8) begin
              oe_n = 1'b0;
            end else begin
              cnt_n   = '0;
              state_n = nxt;
              if (nxt == ST_RD) begin
                oe_n = ~rdata[7];
                sh_n = {rdata[6:0], 1'b0};
              end else begin
                oe_n = 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state  <= ST_IDLE;
      nxt    <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sda_oe <= 1'b0;
      ack    <= 1'b0;
      addr   <= '0;
      hi     <= '0;
    end else begin
      state  <= state_n;
      nxt    <= nxt_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      sda_oe <= oe_n;
      ack    <= ack_n;
      addr   <= addr_n;
      hi     <= hi_n;
    end
  end
endmodule

// File: rtl/eep_i2c_target_chk.sv
module eep_i2c_target_chk
  import eep_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sda_oe,
  input logic               scl_s,
  input logic               stop_evt,
  input logic               busy,
  input logic               wp,
  input logic [(1<<PW)-1:0] buf_valid,
  input eep_state_e         state,
  input logic [AW-1:0]      addr
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_evt) |-> !sda_oe); // R1

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R11

  AST_WP_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(buf_valid) > $countones($past(buf_valid))) |-> !$past(wp)); // R6

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR && $past(state) == ST_WR) |-> (addr[AW-1:PW] == $past(addr[AW-1:PW]))); // R4
endmodule

bind eep_i2c_target eep_i2c_target_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .sda_oe    (sda_oe),
  .scl_s     (scl_s),
  .stop_evt  (stop_evt),
  .busy      (busy),
  .wp        (wp),
  .buf_valid (buf_valid),
  .state     (state),
  .addr      (addr)
);

// File: tb/eep_i2c_target_tb.sv
module eep_i2c_target_tb;
  localparam int Q  = 8;
  localparam int WC = 2000;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl;
  logic m_sda;
  logic wp;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] rd_buf [16];

  always #5 clk = ~clk;

  eep_i2c_target #(.WC_CYCLES(WC)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (m_scl),
    .sda_in (sda_bus),
    .wp     (wp),
    .sda_oe (sda_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bstart;
    m_sda = 1'b1; tq();
    m_scl = 1'b1; tq();
    m_sda = 1'b0; tq();
    m_scl = 1'b0; tq();
  endtask

  task automatic bstop;
    m_sda = 1'b0; tq();
    m_scl = 1'b1; tq();
    m_sda = 1'b1; tq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tq();
      m_scl = 1'b1; tq(2);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; tq();
    m_scl = 1'b1; tq();
    ack = sda_bus; tq();
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tq();
      m_scl = 1'b1; tq();
      b[i] = sda_bus; tq();
      m_scl = 1'b0;
    end
    m_sda = mack; tq();
    m_scl = 1'b1; tq(2);
    m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic wait_wc;
    repeat (WC + 100) @(negedge clk);
  endtask

  task automatic page_write(input logic [10:0] a, input int n, input logic [7:0] first,
                            input string tag, input logic exp_dack);
    logic ack;
    bstart;
    send_byte({4'b1010, a[10:8], 1'b0}, ack);
    chk({tag, " device ack"}, ack, 0);
    send_byte(a[7:0], ack);
    chk({tag, " address ack"}, ack, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(first + 8'(i), ack);
      chk({tag, " data ack"}, ack, exp_dack);
    end
    bstop;
  endtask

  task automatic do_read(input logic rnd, input logic [10:0] a, input int n, input string tag);
    logic ack;
    if (rnd) begin
      bstart;
      send_byte({4'b1010, a[10:8], 1'b0}, ack);
      chk({tag, " dummy device ack"}, ack, 0);
      send_byte(a[7:0], ack);
      chk({tag, " dummy address ack"}, ack, 0);
    end
    bstart;
    send_byte({4'b1010, a[10:8], 1'b1}, ack);
    chk({tag, " read device ack"}, ack, 0);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rd_buf[i]);
    bstop;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tq(2);
    chk("R12 sda_oe low in reset", sda_oe, 0);
    rst_n = 1'b1; tq(2);
    chk("R12 sda_oe low after reset", sda_oe, 0);
    page_write(11'h000, 3, 8'h10, "R4 low page", 1'b0);
    wait_wc;
    rst_n = 1'b0; tq(); rst_n = 1'b1; tq(2);
    do_read(1'b0, 11'h7FF, 1, "R12 counter reset");
    chk("R12 R7 current read after reset", rd_buf[0], 8'h10);
  endtask

  task automatic t_byte_poll;
    logic ack;
    page_write(11'h123, 1, 8'hA5, "R4 byte", 1'b0);
    bstart;
    send_byte(8'b1010_0010, ack);
    chk("R11 poll during write cycle", ack, 1);
    bstop;
    wait_wc;
    bstart;
    send_byte(8'b1010_0010, ack);
    chk("R11 poll after write cycle", ack, 0);
    bstop;
    do_read(1'b1, 11'h123, 1, "R8 random");
    chk("R8 random read data", rd_buf[0], 8'hA5);
  endtask

  task automatic t_bad_dev;
    logic ack;
    bstart;
    send_byte(8'b1001_0010, ack);
    chk("R2 wrong code no ack", ack, 1);
    send_byte(8'h00, ack);
    chk("R2 following byte ignored", ack, 1);
    bstop;
  endtask

  task automatic t_page;
    page_write(11'h2F0, 16, 8'h40, "R4 full page", 1'b0);
    wait_wc;
    do_read(1'b0, 11'h000, 1, "R5 counter after page");
    chk("R5 counter back at page start", rd_buf[0], 8'h40);
    page_write(11'h2FE, 3, 8'h90, "R5 wrap write", 1'b0);
    wait_wc;
    do_read(1'b0, 11'h000, 1, "R7 current");
    chk("R7 current read last+1", rd_buf[0], 8'h41);
    do_read(1'b1, 11'h2FE, 2, "R5 page end");
    chk("R5 byte at 0x2FE", rd_buf[0], 8'h90);
    chk("R5 byte at 0x2FF", rd_buf[1], 8'h91);
    do_read(1'b1, 11'h2F0, 1, "R5 overwrite");
    chk("R5 wrapped byte overwrote page start", rd_buf[0], 8'h92);
  endtask

  task automatic t_seq_wrap;
    page_write(11'h7FE, 2, 8'hC0, "R4 top", 1'b0);
    wait_wc;
    do_read(1'b1, 11'h7FE, 4, "R9 sequential");
    chk("R9 seq byte 0", rd_buf[0], 8'hC0);
    chk("R9 seq byte 1", rd_buf[1], 8'hC1);
    chk("R9 seq wrap to 0x000", rd_buf[2], 8'h10);
    chk("R9 seq byte 0x001", rd_buf[3], 8'h11);
    do_read(1'b0, 11'h000, 1, "R10 counter");
    chk("R10 counter one past last sent", rd_buf[0], 8'h12);
  endtask

  task automatic t_abort;
    logic ack;
    logic [7:0] b;
    bstart;
    send_byte(8'b1010_0010, ack);
    chk("R1 abort device ack", ack, 0);
    send_byte(8'h23, ack);
    chk("R1 abort address ack", ack, 0);
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b0; tq();
      m_scl = 1'b1; tq(2);
      m_scl = 1'b0;
    end
    bstart;
    send_byte(8'b1010_0011, ack);
    chk("R1 read after repeated START ack", ack, 0);
    recv_byte(1'b1, b);
    bstop;
    chk("R1 partial byte not stored", b, 8'hA5);
    bstart;
    send_byte(8'b1010_0010, ack);
    chk("R1 no write cycle after abort", ack, 0);
    bstop;
  endtask

  task automatic t_wp;
    logic ack;
    wp = 1'b1;
    page_write(11'h123, 2, 8'h5A, "R6 protected", 1'b1);
    wp = 1'b0;
    bstart;
    send_byte(8'b1010_0010, ack);
    chk("R6 no write cycle started", ack, 0);
    bstop;
    do_read(1'b1, 11'h123, 1, "R6 readback");
    chk("R6 array unchanged", rd_buf[0], 8'hA5);
  endtask

  task automatic t_nack_hold;
    logic ack;
    logic [7:0] b;
    bstart;
    send_byte(8'b1010_0011, ack);
    chk("R10 read device ack", ack, 0);
    recv_byte(1'b1, b);
    recv_byte(1'b1, b);
    chk("R10 line released after no-ack", b, 8'hFF);
    bstop;
  endtask

  initial begin
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    wp    = 1'b0;
    t_reset;
    t_byte_poll;
    t_bad_dev;
    t_page;
    t_seq_wrap;
    t_abort;
    t_wp;
    t_nack_hold;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule